// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block produces the word addresses for one channel of a strided two-dimensional transfer. A start pulse samples a start word address, a line length, a stride and a line count minus one. The block then offers one word address per cycle on a valid/ready pair. Each line covers consecutive words. The next line begins one stride past the start of the previous one, so the words between the end of a line and the stride are skipped.

A line length of zero selects a ring mode. In ring mode the address climbs through a region of stride × (line count + 1) words and then returns to the start address. This repeats until a stop request arrives. The region is treated as two halves, and a pulse marks the end of each half on every pass. In normal mode a single completion pulse follows the last word of the last line. A stop request aborts either mode quietly.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After a synchronous active-low reset, `addr_valid`, `xfer_done`, `ring_half_a` and `ring_half_b` are all low. Pulsing `ready` with no start leaves `addr_valid` low.
- R2: In normal mode (`cfg_len` ≠ 0), the addresses come in this order: line i, word j gives `cfg_base` + i·`cfg_stride` + j. Here j runs from 0 to `cfg_len`−1 and i runs from 0 to `cfg_lines`. A `cfg_lines` value of 0 therefore means a single line.
- R3: The address advances only on a cycle where `addr_valid` and `ready` are both high. Otherwise it holds.
- R4: In normal mode, `xfer_done` is high for exactly one cycle: the cycle after the final handshake. `addr_valid` is low in that same cycle.
- R5: In ring mode (`cfg_len` = 0), the n-th handshake of a pass carries `cfg_base` + n. The region is S = `cfg_stride`·(`cfg_lines`+1) words. After word S−1 the address returns to `cfg_base`, and this repeats without end.
- R6: In ring mode, `ring_half_a` pulses for one cycle after the handshake of word floor(S/2)−1 (an odd S rounds down). `ring_half_b` pulses for one cycle after the handshake of word S−1. Both happen on every pass, and the two never pulse in the same cycle.
- R7: When `stop` is high in a busy cycle, `addr_valid` is low from the next cycle on. No handshake is taken in that cycle and no completion pulse is raised. A later start runs normally.
- R8: A start pulse while `addr_valid` is high is ignored. The running sequence and its configuration are unchanged.
- R9: `addr_valid` rises in the cycle after an accepted start and carries `cfg_base` first. The configuration inputs are sampled only at that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| stop | input | 1 | Abort the sequence, return to idle |
| cfg_base | input | AW | Start word address |
| cfg_len | input | LW | Words per line; 0 selects ring mode |
| cfg_stride | input | LW | Words from one line start to the next |
| cfg_lines | input | CW | Number of lines minus one |
| ready | input | 1 | Downstream accepts the current address |
| addr_valid | output | 1 | Current address is valid |
| addr | output | AW | Current word address |
| xfer_done | output | 1 | One-cycle pulse after the last normal-mode word |
| ring_half_a | output | 1 | One-cycle pulse at the end of the first ring half |
| ring_half_b | output | 1 | One-cycle pulse at the end of the second ring half |

## Verification
All outputs are registered.

| Stimulus | Result due |
|---|---|
| Start pulse | `addr_valid` and `cfg_base`, one edge later |
| Handshake edge | Next address, one edge later |
| Final normal-mode handshake | `xfer_done`, one edge later |
| Half-boundary handshake in ring mode | Half pulse, one edge later |
| Stop | `addr_valid` low, one edge later |

The bench changes inputs only on the falling edge. Before it sets new inputs there, it compares the outputs against a model of the expected sequence. As a result, each expected event is checked exactly one cycle after the handshake that the model recorded for it. Stall patterns hold `ready` low on chosen cycles to show that the address holds there.

// File: rtl/dma2d_pkg.sv
// Shared definitions for the two-dimensional address sequencer.
// Assumes nothing beyond standard SystemVerilog packages.
package dma2d_pkg;
    // Default widths: word address, line length/stride, line count.
    localparam int DEF_AW = 32;
    localparam int DEF_LW = 16;
    localparam int DEF_CW = 16;

    // Sequencer activity states.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/dma2d_walker.sv
// Address walker: holds the sampled configuration and the position counters.
// It steps the word address on each accepted handshake.
// Assumes: load and step are never high together; in ring mode stride >= 1.
module dma2d_walker #(
    parameter int AW = dma2d_pkg::DEF_AW,
    parameter int LW = dma2d_pkg::DEF_LW,
    parameter int CW = dma2d_pkg::DEF_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] cfg_base,
    input  logic [LW-1:0] cfg_len,
    input  logic [LW-1:0] cfg_stride,
    input  logic [CW-1:0] cfg_lines,
    output logic [AW-1:0] addr_q,
    output logic          ring_mode,
    output logic          at_end,
    output logic          at_half,
    output logic          at_wrap
);
    localparam int PW = LW + CW + 1;

    logic [AW-1:0] base_r, line_start;
    logic [LW-1:0] len_r, stride_r, word_cnt;
    logic [CW-1:0] lines_r, line_cnt;
    logic [PW-1:0] region_r, ptr;
    logic          loop_r;
    logic          last_word;
    logic [PW-1:0] ptr_nx;
    logic [AW-1:0] next_line;

    // Position decode for the current word.
    always_comb begin
        ptr_nx    = ptr + PW'(1);
        next_line = line_start + AW'(stride_r);
        last_word = (word_cnt == LW'(len_r - LW'(1)));
        at_end    = last_word && (line_cnt == lines_r);
        at_half   = ((region_r >> 1) != '0) && (ptr_nx == (region_r >> 1));
        at_wrap   = (ptr_nx == region_r);
    end

    assign ring_mode = loop_r;

    // Configuration capture and counter/address stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_r     <= '0;
            line_start <= '0;
            addr_q     <= '0;
            len_r      <= '0;
            stride_r   <= '0;
            lines_r    <= '0;
            word_cnt   <= '0;
            line_cnt   <= '0;
            ptr        <= '0;
            region_r   <= '0;
            loop_r     <= 1'b0;
        end else if (load) begin
            base_r     <= cfg_base;
            line_start <= cfg_base;
            addr_q     <= cfg_base;
            len_r      <= cfg_len;
            stride_r   <= cfg_stride;
            lines_r    <= cfg_lines;
            word_cnt   <= '0;
            line_cnt   <= '0;
            ptr        <= '0;
            region_r   <= PW'(cfg_stride) * (PW'(cfg_lines) + PW'(1));
            loop_r     <= (cfg_len == '0);
        end else if (step) begin
            if (loop_r) begin
                if (at_wrap) begin
                    ptr    <= '0;
                    addr_q <= base_r;
                end else begin
                    ptr    <= ptr_nx;
                    addr_q <= addr_q + AW'(1);
                end
            end else if (last_word) begin
                word_cnt   <= '0;
                line_cnt   <= line_cnt + CW'(1);
                line_start <= next_line;
                addr_q     <= next_line;
            end else begin
                word_cnt <= word_cnt + LW'(1);
                addr_q   <= addr_q + AW'(1);
            end
        end
    end

    // R2: inside a line the address moves by exactly one word.
    a_r2_line_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !loop_r && !last_word) |=> (addr_q == $past(addr_q) + AW'(1)));

    // R5: a ring wrap returns the address to the sampled base.
    a_r5_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
        (step && loop_r && at_wrap) |=> (addr_q == base_r));
endmodule

// File: rtl/dma2d_seq_ctrl.sv
// Sequencer control: run/idle state, start and stop arbitration, and
// registered one-cycle event pulses.
// Assumes the walker flags describe the address currently offered.
module dma2d_seq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic ready,
    input  logic ring_mode,
    input  logic at_end,
    input  logic at_half,
    input  logic at_wrap,
    output logic busy,
    output logic load,
    output logic step,
    output logic done_q,
    output logic half_a_q,
    output logic half_b_q
);
    import dma2d_pkg::*;

    seq_state_t state;
    logic       finish;

    // Handshake qualification; stop overrides both load and step.
    always_comb begin
        busy   = (state == SEQ_RUN);
        load   = !busy && start && !stop;
        step   = busy && ready && !stop;
        finish = step && !ring_mode && at_end;
    end

    // State register and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            done_q   <= 1'b0;
            half_a_q <= 1'b0;
            half_b_q <= 1'b0;
        end else begin
            done_q   <= finish;
            half_a_q <= step && ring_mode && at_half;
            half_b_q <= step && ring_mode && at_wrap;
            if (stop || finish)
                state <= SEQ_IDLE;
            else if (load)
                state <= SEQ_RUN;
        end
    end

    // R4: the completion pulse coincides with idle.
    a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy);

    // R7: a stop leaves the block idle with no completion.
    a_r7_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!busy && !done_q && !half_a_q && !half_b_q));

    // R6: at most one event per cycle.
    a_r6_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_q, half_a_q, half_b_q}));

    // R6: half events occur while the ring keeps running.
    a_r6_ring_runs_on: assert property (@(posedge clk) disable iff (!rst_n)
        (half_a_q || half_b_q) |-> busy);
endmodule

// File: rtl/dma2d_addr_gen.sv
// Two-dimensional address sequencer top: joins the control and the walker.
// Assumes one channel; ring mode requires cfg_stride >= 1.
module dma2d_addr_gen #(
    parameter int AW = dma2d_pkg::DEF_AW,
    parameter int LW = dma2d_pkg::DEF_LW,
    parameter int CW = dma2d_pkg::DEF_CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    input  logic [AW-1:0] cfg_base,
    input  logic [LW-1:0] cfg_len,
    input  logic [LW-1:0] cfg_stride,
    input  logic [CW-1:0] cfg_lines,
    input  logic          ready,
    output logic          addr_valid,
    output logic [AW-1:0] addr,
    output logic          xfer_done,
    output logic          ring_half_a,
    output logic          ring_half_b
);
    logic load, step, ring_mode, at_end, at_half, at_wrap, busy;

    dma2d_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .ready     (ready),
        .ring_mode (ring_mode),
        .at_end    (at_end),
        .at_half   (at_half),
        .at_wrap   (at_wrap),
        .busy      (busy),
        .load      (load),
        .step      (step),
        .done_q    (xfer_done),
        .half_a_q  (ring_half_a),
        .half_b_q  (ring_half_b)
    );

    dma2d_walker #(.AW(AW), .LW(LW), .CW(CW)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .cfg_base   (cfg_base),
        .cfg_len    (cfg_len),
        .cfg_stride (cfg_stride),
        .cfg_lines  (cfg_lines),
        .addr_q     (addr),
        .ring_mode  (ring_mode),
        .at_end     (at_end),
        .at_half    (at_half),
        .at_wrap    (at_wrap)
    );

    assign addr_valid = busy;

    // R3: a stalled address holds until it is accepted.
    a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !ready) |=> $stable(addr));

    // R9: valid rises only in response to a start.
    a_r9_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_valid) |-> $past(start));
endmodule

// File: tb/tb_dma2d_addr_gen.sv
// Directed bench for the two-dimensional address sequencer.
module tb_dma2d_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [15:0] cfg_len = '0;
    logic [15:0] cfg_stride = '0;
    logic [15:0] cfg_lines = '0;
    logic        ready = 1'b0;
    logic        addr_valid, xfer_done, ring_half_a, ring_half_b;
    logic [31:0] addr;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    dma2d_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_stride(cfg_stride),
        .cfg_lines(cfg_lines), .ready(ready), .addr_valid(addr_valid),
        .addr(addr), .xfer_done(xfer_done), .ring_half_a(ring_half_a),
        .ring_half_b(ring_half_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Runs one sequence; stops after max_words handshakes if it has not ended;
    // optionally pokes a start with other settings at handshake poke_at.
    task automatic run_xfer(input string name, input logic [31:0] b, input logic [15:0] ln,
                            input logic [15:0] st, input logic [15:0] lc, input bit stall,
                            input int max_words, input int poke_at);
        int i = 0, j = 0, p = 0, consumed = 0, cyc = 0;
        int s_sz = st * (lc + 1);
        int h_sz = s_sz / 2;
        bit fin = 0, ed = 0, eha = 0, ehb = 0, poked = 0;
        logic [31:0] ea;
        @(negedge clk);
        cfg_base = b; cfg_len = ln; cfg_stride = st; cfg_lines = lc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({name, " R9 valid after start"}, addr_valid, 1);
        chk({name, " R9 first address"}, addr, b);
        while (1) begin
            chk({name, " R4 done pulse"}, xfer_done, ed);
            chk({name, " R6 half A pulse"}, ring_half_a, eha);
            chk({name, " R6 half B pulse"}, ring_half_b, ehb);
            if (fin) break;
            if (consumed == max_words) begin
                stop = 1'b1; ready = 1'b1;
                @(negedge clk);
                stop = 1'b0; ready = 1'b0;
                chk({name, " R7 idle after stop"}, addr_valid, 0);
                chk({name, " R7 no done on stop"}, xfer_done, 0);
                @(negedge clk);
                chk({name, " R7 still idle"}, addr_valid, 0);
                chk({name, " R7 still no done"}, xfer_done, 0);
                return;
            end
            ea = (ln == 0) ? b + p : b + i * st + j;
            chk({name, (ln == 0) ? " R5 ring address" : " R2 line address"}, addr, ea);
            chk({name, " R8 valid held"}, addr_valid, 1);
            ready = stall ? ((cyc % 3) != 1) : 1'b1;
            if (!poked && consumed == poke_at) begin
                poked = 1; start = 1'b1;
                cfg_base = 32'h0000_BAD0; cfg_len = 16'd1; cfg_stride = 16'd1; cfg_lines = 16'd0;
            end
            ed = 0; eha = 0; ehb = 0;
            if (ready) begin
                consumed++;
                if (ln == 0) begin
                    if (h_sz > 0 && p + 1 == h_sz) eha = 1;
                    if (p + 1 == s_sz) begin ehb = 1; p = 0; end
                    else p++;
                end else if (j == ln - 1) begin
                    j = 0;
                    if (i == lc) begin ed = 1; fin = 1; end
                    else i++;
                end else j++;
            end else begin
                ea = addr;
            end
            cyc++;
            @(negedge clk);
            start = 1'b0; ready = 1'b0;
            if (!ready && !fin && (ea == addr) && stall && ((cyc - 1) % 3 == 1))
                chk({name, " R3 hold on stall"}, addr, ea);
        end
        chk({name, " R4 idle with done"}, addr_valid, 0);
        @(negedge clk);
        chk({name, " R4 done one cycle"}, xfer_done, 0);
    endtask

    task automatic t_reset();
        chk("R1 valid low", addr_valid, 0);
        chk("R1 done low", xfer_done, 0);
        chk("R1 half A low", ring_half_a, 0);
        chk("R1 half B low", ring_half_b, 0);
        @(negedge clk); ready = 1'b1;
        @(negedge clk); ready = 1'b0;
        chk("R1 ready alone no start", addr_valid, 0);
    endtask

    initial begin
        #(8 * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_xfer("normal", 32'h100, 16'd4, 16'd6, 16'd2, 0, 1000, -1);
        run_xfer("normal_stall", 32'h2000, 16'd3, 16'd8, 16'd3, 1, 1000, -1);
        run_xfer("single_word", 32'h55, 16'd1, 16'd1, 16'd0, 0, 1000, -1);
        run_xfer("busy_start_R8", 32'h300, 16'd2, 16'd5, 16'd2, 0, 1000, 2);
        run_xfer("stop_normal_R7", 32'h400, 16'd4, 16'd4, 16'd3, 0, 5, -1);
        run_xfer("after_stop", 32'h480, 16'd2, 16'd3, 16'd1, 0, 1000, -1);
        run_xfer("ring_even", 32'h1000, 16'd0, 16'd4, 16'd1, 0, 20, -1);
        run_xfer("ring_odd", 32'h1800, 16'd0, 16'd5, 16'd0, 1, 13, -1);
        run_xfer("ring_busy_start", 32'h1900, 16'd0, 16'd3, 16'd1, 0, 14, 4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule